// File: doc/BRIEF.md
# Shared-Address Row Activation Tracker

This block sits beside a DRAM memory controller and watches every row-activate command sent to one rank. It counts activations per row address. A row address has one count, whatever bank the activate went to. The counts live in a small table that is looked up by row address. Each table slot also holds a bit vector of the banks that opened that row since the slot was last filled or cleared.

When a slot's count reaches the threshold, the block presents a mitigation request on a ready/valid output. The request carries the row address and the bank vector. When the request is accepted, that slot's count and bank vector start again from zero. A refresh-window pulse empties the whole table.

If an activate misses and every slot is in use, the slot with the lowest count is taken over. The new row inherits that count plus one, so no tracked row is ever reported below its true activation count. The table holds far fewer slots than there are bank-row pairs; the smallest configuration has a single slot.

Top module: `shact_tracker`

## Requirements
- R1: Activates to one row address in different banks advance a single shared count. The table never holds the same row address in two slots.
- R2: The request's bank vector has bit n set exactly when bank n activated the row since the slot was last filled or cleared.
- R3: A request is raised in the cycle after a slot's count reaches THRESH (default 125; 1000 must also be supported). If several slots are at the limit, the lowest index is served first.
- R4: While a request is valid and not accepted, and no window clear arrives, it stays valid and its row address does not change.
- R5: On acceptance (req_vld and req_rdy both high at a clock edge), that slot's count and bank vector return to zero and the request drops for at least one cycle.
- R6: An activate to the accepted slot's row in the acceptance cycle counts as the first activation of the fresh count, and its bank is the only bit set.
- R7: A missing activate that finds an empty slot fills it with count 1 and only its own bank bit set.
- R8: A missing activate with no empty slot takes over the slot with the lowest count (lowest index on a tie), which gets that count plus one. The slot behind a pending request is never taken; if no other slot exists, the activate is not recorded.
- R9: A window clear empties every slot and withdraws any pending request. An activate in the same cycle is recorded after the clear, with count 1.
- R10: NUM_BANKS accepts 16, 32 or 64 with the same per-address slot structure; bank 63 is bit 63 of the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_vld | input | 1 | Row-activate command seen this cycle |
| act_bank | input | $clog2(NUM_BANKS) | Bank of the activate |
| act_row | input | ROW_W | Row address of the activate |
| win_clr | input | 1 | Refresh-window pulse; empties the table |
| req_vld | output | 1 | Mitigation request valid |
| req_rdy | input | 1 | Mitigation request accepted |
| req_row | output | ROW_W | Row address to mitigate |
| req_banks | output | NUM_BANKS | Banks that activated that row |

## Verification
The first pattern spreads one row across several banks. It shows whether the count is shared and whether every bank lands in the vector. The second places an activate on the accepted row in the very acceptance cycle. It tells a fresh count of one apart from a lost activate or an uncleared vector, because the next request appears after exactly THRESH-1 further activates. A full table with uneven counts then shows, through how many further activates the new row needs, which slot was taken over and from what count it started. A window clear with a concurrent activate separates clear-then-count from count-then-clear. A one-slot, 64-bank instance at a threshold of 125 checks the top bank bit and the refusal to evict a pending row.

// File: rtl/shact_pkg.sv
package shact_pkg;
  // width of a counter that must hold 0..lim
  function automatic int unsigned cnt_bits(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // width of an index into n slots (at least one bit)
  function automatic int unsigned idx_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/shact_lookup.sv
module shact_lookup #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ROW_W       = 16,
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_ENTRIES-1:0] slot_vld,
  input  logic [ROW_W-1:0] slot_row [NUM_ENTRIES],
  input  logic [CNT_W-1:0] slot_cnt [NUM_ENTRIES],
  input  logic [ROW_W-1:0] key_row,
  input  logic             guard_vld,
  input  logic [IDX_W-1:0] guard_idx,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             free_found,
  output logic [IDX_W-1:0] free_idx,
  output logic             vict_found,
  output logic [IDX_W-1:0] vict_idx,
  output logic [CNT_W-1:0] vict_cnt
);
  logic [NUM_ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = slot_vld[g] && (slot_row[g] == key_row);
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    free_found = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i] && !hit) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!slot_vld[i] && !free_found) begin
        free_found = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // lowest count wins, earlier index wins a tie, pending slot is skipped
  always_comb begin
    vict_found = 1'b0;
    vict_idx = '0;
    vict_cnt = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!(guard_vld && guard_idx == IDX_W'(i))) begin
        if (!vict_found || slot_cnt[i] < vict_cnt) begin
          vict_found = 1'b1;
          vict_idx = IDX_W'(i);
          vict_cnt = slot_cnt[i];
        end
      end
    end
  end

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R1

  AST_VICTIM_SPARES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (vict_found && guard_vld) |-> (vict_idx != guard_idx)); // R8
endmodule

// File: rtl/shact_reqsel.sv
module shact_reqsel #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned THRESH      = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_ENTRIES-1:0] slot_vld,
  input  logic [CNT_W-1:0] slot_cnt [NUM_ENTRIES],
  input  logic             clr,
  input  logic             accept,
  output logic             pend_q,
  output logic [IDX_W-1:0] pend_idx_q
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(THRESH);

  logic [NUM_ENTRIES-1:0] at_lim;
  logic                   pick;
  logic [IDX_W-1:0]       pick_idx;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_lim
    assign at_lim[g] = slot_vld[g] && (slot_cnt[g] >= LIM);
  end

  always_comb begin
    pick = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (at_lim[i] && !pick) begin
        pick = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pend_idx_q <= '0;
    end else if (clr || accept) begin
      pend_q <= 1'b0;
    end else if (!pend_q && pick) begin
      pend_q <= 1'b1;
      pend_idx_q <= pick_idx;
    end
  end

  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && accept) |=> !pend_q); // R5

  AST_CLEAR_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend_q); // R9
endmodule

// File: rtl/shact_tracker.sv
module shact_tracker #(
  parameter int unsigned NUM_BANKS   = 16,
  parameter int unsigned ROW_W       = 16,
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned THRESH      = 125
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         act_vld,
  input  logic [$clog2(NUM_BANKS)-1:0] act_bank,
  input  logic [ROW_W-1:0]             act_row,
  input  logic                         win_clr,
  output logic                         req_vld,
  input  logic                         req_rdy,
  output logic [ROW_W-1:0]             req_row,
  output logic [NUM_BANKS-1:0]         req_banks
);
  localparam int unsigned CNT_W = shact_pkg::cnt_bits(THRESH);
  localparam int unsigned IDX_W = shact_pkg::idx_bits(NUM_ENTRIES);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(THRESH);

  initial begin
    if (THRESH < 2) $error("THRESH must be at least 2");
  end

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur);
    return (cur >= LIM) ? LIM : cur + 1'b1;
  endfunction

  logic [NUM_ENTRIES-1:0] ent_vld_q;
  logic [ROW_W-1:0]       ent_row_q   [NUM_ENTRIES];
  logic [CNT_W-1:0]       ent_cnt_q   [NUM_ENTRIES];
  logic [NUM_BANKS-1:0]   ent_banks_q [NUM_ENTRIES];

  // view of the table after this cycle's clear / acceptance
  logic [NUM_ENTRIES-1:0] eff_vld;
  logic [CNT_W-1:0]       eff_cnt   [NUM_ENTRIES];
  logic [NUM_BANKS-1:0]   eff_banks [NUM_ENTRIES];

  logic                 accept;
  logic [IDX_W-1:0]     req_idx;
  logic [NUM_BANKS-1:0] bank_1h;
  logic                 guard_vld;
  logic                 hit, free_found, vict_found;
  logic [IDX_W-1:0]     hit_idx, free_idx, vict_idx;
  logic [CNT_W-1:0]     vict_cnt;

  assign accept    = req_vld && req_rdy;
  assign bank_1h   = NUM_BANKS'(1) << act_bank;
  assign guard_vld = req_vld && !accept && !win_clr;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      eff_vld[i] = ent_vld_q[i] && !win_clr;
      if (win_clr || (accept && req_idx == IDX_W'(i))) begin
        eff_cnt[i] = '0;
        eff_banks[i] = '0;
      end else begin
        eff_cnt[i] = ent_cnt_q[i];
        eff_banks[i] = ent_banks_q[i];
      end
    end
  end

  shact_lookup #(
    .NUM_ENTRIES(NUM_ENTRIES), .ROW_W(ROW_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .slot_vld(eff_vld), .slot_row(ent_row_q), .slot_cnt(eff_cnt),
    .key_row(act_row), .guard_vld(guard_vld), .guard_idx(req_idx),
    .hit(hit), .hit_idx(hit_idx),
    .free_found(free_found), .free_idx(free_idx),
    .vict_found(vict_found), .vict_idx(vict_idx), .vict_cnt(vict_cnt)
  );

  shact_reqsel #(
    .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W), .THRESH(THRESH)
  ) u_reqsel (
    .clk(clk), .rst_n(rst_n),
    .slot_vld(ent_vld_q), .slot_cnt(ent_cnt_q),
    .clr(win_clr), .accept(accept),
    .pend_q(req_vld), .pend_idx_q(req_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_row_q[i] <= '0;
        ent_cnt_q[i] <= '0;
        ent_banks_q[i] <= '0;
      end
    end else begin
      ent_vld_q <= eff_vld;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_cnt_q[i] <= eff_cnt[i];
        ent_banks_q[i] <= eff_banks[i];
      end
      if (act_vld) begin
        if (hit) begin
          ent_cnt_q[hit_idx] <= cnt_step(eff_cnt[hit_idx]);
          ent_banks_q[hit_idx] <= eff_banks[hit_idx] | bank_1h;
        end else if (free_found) begin
          ent_vld_q[free_idx] <= 1'b1;
          ent_row_q[free_idx] <= act_row;
          ent_cnt_q[free_idx] <= CNT_W'(1);
          ent_banks_q[free_idx] <= bank_1h;
        end else if (vict_found) begin
          ent_row_q[vict_idx] <= act_row;
          ent_cnt_q[vict_idx] <= cnt_step(vict_cnt);
          ent_banks_q[vict_idx] <= bank_1h;
        end
      end
    end
  end

  assign req_row   = ent_row_q[req_idx];
  assign req_banks = ent_banks_q[req_idx];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_rdy && !win_clr) |=> (req_vld && $stable(req_row))); // R4

  AST_REQ_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> (ent_cnt_q[req_idx] == LIM)); // R3

  AST_REQ_HAS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> (req_banks != '0)); // R2
endmodule

// File: tb/sim_shact_tracker.sv
`timescale 1ns/1ps
module sim_shact_tracker;
  localparam int T  = 6;
  localparam int NE = 4;
  localparam int T1 = 125;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic a_vld = 1'b0, a_clr = 1'b0, a_rdy = 1'b0;
  logic [3:0] a_bank = '0;
  logic [15:0] a_row = '0;
  logic r_vld;
  logic [15:0] r_row;
  logic [15:0] r_banks;

  shact_tracker #(.NUM_BANKS(16), .ROW_W(16), .NUM_ENTRIES(NE), .THRESH(T)) u0 (
    .clk(clk), .rst_n(rst_n), .act_vld(a_vld), .act_bank(a_bank), .act_row(a_row),
    .win_clr(a_clr), .req_vld(r_vld), .req_rdy(a_rdy), .req_row(r_row), .req_banks(r_banks));

  logic b_vld = 1'b0, b_rdy = 1'b0;
  logic [5:0] b_bank = '0;
  logic [11:0] b_row = '0;
  logic q_vld;
  logic [11:0] q_row;
  logic [63:0] q_banks;

  shact_tracker #(.NUM_BANKS(64), .ROW_W(12), .NUM_ENTRIES(1), .THRESH(T1)) u1 (
    .clk(clk), .rst_n(rst_n), .act_vld(b_vld), .act_bank(b_bank), .act_row(b_row),
    .win_clr(1'b0), .req_vld(q_vld), .req_rdy(b_rdy), .req_row(q_row), .req_banks(q_banks));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent reference table for u0
  bit m_v[NE];
  int m_r[NE];
  int m_c[NE];
  int m_b[NE];
  bit m_p;
  int m_i;

  task automatic m_reset();
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_r[i] = 0; m_c[i] = 0; m_b[i] = 0; end
    m_p = 0; m_i = 0;
  endtask

  task automatic m_update(input bit a, input int b, input int r, input bit c, input bit y);
    int oc[NE];
    bit hs;
    int prot, h, f, v;
    for (int i = 0; i < NE; i++) oc[i] = m_v[i] ? m_c[i] : 0;
    hs = m_p && y;
    prot = (m_p && !hs && !c) ? m_i : -1;
    if (c) begin
      for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_c[i] = 0; m_b[i] = 0; end
    end else if (hs) begin
      m_c[m_i] = 0; m_b[m_i] = 0;
    end
    if (a) begin
      h = -1; f = -1; v = -1;
      for (int i = 0; i < NE; i++) if (h < 0 && m_v[i] && m_r[i] == r) h = i;
      for (int i = 0; i < NE; i++) if (f < 0 && !m_v[i]) f = i;
      if (h >= 0) begin
        m_c[h] = (m_c[h] + 1 > T) ? T : m_c[h] + 1;
        m_b[h] = m_b[h] | (1 << b);
      end else if (f >= 0) begin
        m_v[f] = 1; m_r[f] = r; m_c[f] = 1; m_b[f] = 1 << b;
      end else begin
        for (int i = 0; i < NE; i++) if (i != prot && (v < 0 || m_c[i] < m_c[v])) v = i;
        if (v >= 0) begin
          m_r[v] = r; m_c[v] = (m_c[v] + 1 > T) ? T : m_c[v] + 1; m_b[v] = 1 << b;
        end
      end
    end
    if (c || hs) m_p = 0;
    else if (!m_p) begin
      for (int i = 0; i < NE; i++) if (!m_p && oc[i] >= T) begin m_p = 1; m_i = i; end
    end
  endtask

  // one clock of u0 stimulus; returns at the next falling edge
  task automatic step(input bit a, input int b, input int r, input bit c, input bit y);
    a_vld = a; a_bank = 4'(b); a_row = 16'(r); a_clr = c; a_rdy = y;
    @(posedge clk);
    m_update(a, b, r, c, y);
    @(negedge clk);
    a_vld = 0; a_clr = 0; a_rdy = 0;
  endtask

  task automatic act(input int b, input int r);
    step(1, b, r, 0, 0);
  endtask

  task automatic idle(input bit y);
    step(0, 0, 0, 0, y);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_reset();
    @(negedge clk);
  endtask

  task automatic step1(input bit a, input int b, input int r, input bit y);
    b_vld = a; b_bank = 6'(b); b_row = 12'(r); b_rdy = y;
    @(negedge clk);
    b_vld = 0; b_rdy = 0;
  endtask

  typedef struct packed {
    logic        a;
    logic [3:0]  b;
    logic [15:0] r;
    logic        c;
    logic        y;
  } vec_t;

  localparam vec_t VECS[24] = '{
    '{1'b1, 4'd0, 16'h0001, 1'b0, 1'b0}, '{1'b1, 4'd1, 16'h0001, 1'b0, 1'b0},
    '{1'b1, 4'd2, 16'h0001, 1'b0, 1'b0}, '{1'b1, 4'd3, 16'h0001, 1'b0, 1'b0},
    '{1'b1, 4'd4, 16'h0001, 1'b0, 1'b0}, '{1'b1, 4'd5, 16'h0001, 1'b0, 1'b0},
    '{1'b0, 4'd0, 16'h0000, 1'b0, 1'b0}, '{1'b1, 4'd9, 16'h0002, 1'b0, 1'b0},
    '{1'b1, 4'd8, 16'h0001, 1'b0, 1'b1}, '{1'b1, 4'd3, 16'h0003, 1'b0, 1'b0},
    '{1'b1, 4'd4, 16'h0004, 1'b0, 1'b0}, '{1'b1, 4'd4, 16'h0004, 1'b0, 1'b0},
    '{1'b1, 4'd7, 16'h0005, 1'b0, 1'b0}, '{1'b1, 4'd7, 16'h0006, 1'b0, 1'b0},
    '{1'b1, 4'd2, 16'h0002, 1'b0, 1'b0}, '{1'b1, 4'd2, 16'h0002, 1'b0, 1'b0},
    '{1'b1, 4'd6, 16'h0002, 1'b0, 1'b0}, '{1'b1, 4'd6, 16'h0002, 1'b0, 1'b0},
    '{1'b1, 4'd1, 16'h0002, 1'b0, 1'b0}, '{1'b0, 4'd0, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 4'd5, 16'h0002, 1'b0, 1'b0}, '{1'b1, 4'd5, 16'h0007, 1'b1, 1'b0},
    '{1'b1, 4'd5, 16'h0007, 1'b0, 1'b0}, '{1'b0, 4'd0, 16'h0000, 1'b0, 1'b1}
  };

  initial begin
    #(20ns * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(r_vld == 1'b0, "R3 reset u0 idle", 64'(r_vld), 0);
    chk(q_vld == 1'b0, "R3 reset u1 idle", 64'(q_vld), 0);

    // vector walk against the reference table
    foreach (VECS[k]) begin
      step(VECS[k].a, int'(VECS[k].b), int'(VECS[k].r), VECS[k].c, VECS[k].y);
      chk(r_vld == m_p, "R3 table req_vld", 64'(r_vld), 64'(m_p));
      if (m_p) begin
        chk(r_row == 16'(m_r[m_i]), "R1 table req_row", 64'(r_row), 64'(m_r[m_i]));
        chk(r_banks == 16'(m_b[m_i]), "R2 table req_banks", 64'(r_banks), 64'(m_b[m_i]));
      end
    end

    do_reset();

    // R1 R2 R3 R7: one row over several banks
    act(0, 16'h00A5); act(3, 16'h00A5); act(5, 16'h00A5);
    act(3, 16'h00A5); act(15, 16'h00A5); act(1, 16'h00A5);
    chk(r_vld == 1'b0, "R3 no request in limit cycle", 64'(r_vld), 0);
    idle(0);
    chk(r_vld == 1'b1, "R3 request one cycle later", 64'(r_vld), 1);
    chk(r_row == 16'h00A5, "R1 shared row named", 64'(r_row), 64'h00A5);
    chk(r_banks == 16'h802B, "R2 bank vector", 64'(r_banks), 64'h802B);

    // R4 hold
    idle(0); idle(0);
    chk(r_vld == 1'b1 && r_row == 16'h00A5, "R4 held while not ready", 64'(r_vld), 1);

    // R5 R6 accept with a concurrent hit
    step(1, 7, 16'h00A5, 0, 1);
    chk(r_vld == 1'b0, "R5 request drops on accept", 64'(r_vld), 0);
    repeat (4) act(2, 16'h00A5);
    idle(0);
    chk(r_vld == 1'b0, "R6 five activates after accept stay below", 64'(r_vld), 0);
    act(2, 16'h00A5);
    idle(0);
    chk(r_vld == 1'b1, "R6 hit in accept cycle counted once", 64'(r_vld), 1);
    chk(r_banks == 16'h0084, "R5 vector restarted", 64'(r_banks), 64'h0084);
    idle(1);

    // R9 window clear with concurrent activate
    repeat (5) act(0, 16'h0001);
    step(1, 4, 16'h0001, 1, 0);
    repeat (4) act(4, 16'h0001);
    idle(0);
    chk(r_vld == 1'b0, "R9 count restarted at one", 64'(r_vld), 0);
    act(4, 16'h0001);
    idle(0);
    chk(r_vld == 1'b1 && r_row == 16'h0001, "R9 activate after clear counted", 64'(r_vld), 1);
    chk(r_banks == 16'h0010, "R9 vector cleared", 64'(r_banks), 64'h0010);
    step(0, 0, 0, 1, 0);
    chk(r_vld == 1'b0, "R9 clear withdraws request", 64'(r_vld), 0);

    // R7 R8 replacement of the lowest count
    repeat (3) act(0, 16'h0100);
    act(0, 16'h0200);
    repeat (2) act(0, 16'h0300);
    repeat (4) act(0, 16'h0400);
    act(9, 16'h0500);
    repeat (3) act(9, 16'h0500);
    idle(0);
    chk(r_vld == 1'b0, "R8 inherited count is lowest plus one", 64'(r_vld), 0);
    act(9, 16'h0500);
    idle(0);
    chk(r_vld == 1'b1 && r_row == 16'h0500, "R8 new row reaches limit", 64'(r_row), 64'h0500);
    chk(r_banks == 16'h0200, "R7 fresh vector holds only own bank", 64'(r_banks), 64'h0200);
    idle(1);

    // R10 64-bank, one-slot instance at threshold 125
    for (int k = 0; k < T1; k++) step1(1, (k % 2 == 0) ? 0 : 63, 7, 0);
    chk(q_vld == 1'b0, "R10 not yet requested", 64'(q_vld), 0);
    step1(0, 0, 0, 0);
    chk(q_vld == 1'b1 && q_row == 12'd7, "R10 request at 125", 64'(q_row), 7);
    chk(q_banks == 64'h8000_0000_0000_0001, "R10 bank 63 bit", q_banks, 64'h8000_0000_0000_0001);
    step1(1, 5, 9, 0);
    chk(q_vld == 1'b1 && q_row == 12'd7, "R8 pending slot not taken", 64'(q_row), 7);
    step1(0, 0, 0, 1);
    chk(q_vld == 1'b0, "R5 single slot accepted", 64'(q_vld), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule